// File: doc/BRIEF.md
# Likely-Branch Resolver with Delay-Slot Cancel

This unit sits beside the decode stage of a simple in-order 32-bit core with one branch delay slot. When the fetched word is a not-equal likely branch, it compares the two operand values the register file supplies and computes the PC-relative destination. It then holds that decision for one instruction slot.

When the next instruction arrives, which is the delay-slot instruction, the unit acts on the held decision. A taken branch lets the slot instruction run and raises a redirect so that the following fetch comes from the held destination. A branch that is not taken raises a cancel for the slot instruction, and fetch falls through.

The unit always behaves as if the branch were predicted taken. It keeps no prediction history. Any control-transfer instruction found in the delay slot raises a diagnostic flag and is otherwise left unresolved.

Top module: `brl_resolve`

## Requirements
- R1: A word is the target branch only when bits 31:26 equal 6'b010101. Bits 25:21 and 20:16 name the two compared registers and bits 15:0 hold the offset. Any other word leaves taken_o, redirect_o and nullify_o low and creates no pending decision.
- R2: In the cycle the branch is presented with valid_i high and no decision pending, taken_o is high exactly when rs_val_i differs from rt_val_i.
- R3: The destination is (branch PC + 4) plus the offset field sign-extended and multiplied by 4, in 32-bit wrap-around arithmetic. It is presented on target_o while the delay-slot instruction is presented.
- R4: pc_i[1:0] is ignored, and target_o[1:0] is always zero when redirect_o is high.
- R5: After a taken branch is accepted, the next valid instruction sees redirect_o high and nullify_o low.
- R6: After a not-taken branch is accepted, the next valid instruction sees nullify_o high and redirect_o low. The two outputs are never high together.
- R7: The decision state changes only in cycles where valid_i and advance_i are both high. Cycles with a stall or a bubble keep the pending decision and its target.
- R8: The active-low asynchronous reset rst_ni discards any pending decision, so no redirect or cancel follows it.
- R9: slot_hazard_o is high when the delay-slot instruction is a control transfer: bits 31:26 in 6'b000001 to 6'b000111 or 6'b0101xx; bits 31:26 equal to zero with bits 5:0 equal to 6'b001000 or 6'b001001; or bits 31:26 equal to 6'b010000 with bit 25 set and bits 5:0 equal to 6'b011000, 6'b011111 or 6'b100000. A branch in the delay slot drives taken_o low and is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word is valid this cycle |
| advance_i | input | 1 | Pipeline moves forward this cycle |
| instr_i | input | 32 | Fetched instruction word |
| pc_i | input | 32 | Address of instr_i |
| rs_val_i | input | 32 | Value of the first compared register |
| rt_val_i | input | 32 | Value of the second compared register |
| taken_o | output | 1 | Branch condition is true (branch cycle) |
| target_o | output | 32 | Held destination address |
| redirect_o | output | 1 | Next fetch comes from target_o |
| nullify_o | output | 1 | Cancel the delay-slot instruction |
| slot_hazard_o | output | 1 | Control transfer found in the delay slot |

## Verification
The branch is driven with operands that differ and operands that match, so that redirect and cancel can be told apart in the slot cycle. Offsets are chosen to be positive, minus one word, the most negative value and one that wraps past the top of the address space; these expose sign-extension and base-address errors. Stalls and bubbles between the branch and its slot, and a branch presented without advance, show whether state moves only on an accepted cycle. Jump, register jump, exception return, nested branch and ordinary ALU words in the slot separate the hazard decode from normal slot handling, and a reset issued while a decision is pending shows that the decision is discarded.

// File: rtl/brl_pkg.sv
package brl_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned OP_W  = 6;
  localparam int unsigned OFF_W = 16;

  localparam logic [OP_W-1:0] OP_BNE_LIKELY = 6'b010101;
  localparam logic [OP_W-1:0] OP_SPECIAL    = 6'b000000;
  localparam logic [OP_W-1:0] OP_COP0       = 6'b010000;

  typedef struct packed {
    logic            taken;
    logic [XLEN-1:0] target;
  } pend_t;
endpackage

// File: rtl/brl_decode.sv
module brl_decode
  import brl_pkg::*;
#(
  parameter int unsigned W     = XLEN,
  parameter int unsigned OFF_B = OFF_W
) (
  input  logic [W-1:0] instr_i,
  input  logic [W-1:0] pc_i,
  output logic         is_br_o,
  output logic         is_ctrl_o,
  output logic [W-1:0] target_o
);
  localparam int unsigned EXT_W = W - OFF_B - 2;

  logic [OP_W-1:0]  op;
  logic [5:0]       funct;
  logic [OFF_B-1:0] imm;
  logic [W-1:0]     seq_pc, offs;

  assign op    = instr_i[W-1 -: OP_W];
  assign funct = instr_i[5:0];
  assign imm   = instr_i[OFF_B-1:0];

  assign is_br_o = (op == OP_BNE_LIKELY);

  always_comb begin
    is_ctrl_o = 1'b0;
    if (op inside {[6'b000001:6'b000111]}) is_ctrl_o = 1'b1;
    if (op[5:2] == 4'b0101)                is_ctrl_o = 1'b1;
    if (op == OP_SPECIAL && funct inside {6'b001000, 6'b001001}) is_ctrl_o = 1'b1;
    if (op == OP_COP0 && instr_i[25] && funct inside {6'b011000, 6'b011111, 6'b100000})
      is_ctrl_o = 1'b1;
  end

  // base is the slot address; low pc bits dropped to keep word alignment
  assign seq_pc   = {pc_i[W-1:2], 2'b00} + W'(4);
  assign offs     = {{EXT_W{imm[OFF_B-1]}}, imm, 2'b00};
  assign target_o = seq_pc + offs;
endmodule

// File: rtl/brl_compare.sv
module brl_compare #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         ne_o
);
  assign ne_o = |(a_i ^ b_i);
endmodule

// File: rtl/brl_slot.sv
module brl_slot
  import brl_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         advance_i,
  input  logic         is_br_i,
  input  logic         is_ctrl_i,
  input  logic         cond_i,
  input  logic [W-1:0] target_i,
  output logic         taken_o,
  output logic         redirect_o,
  output logic         nullify_o,
  output logic         hazard_o,
  output logic [W-1:0] target_o
);
  logic         pend_q, ptaken_q, fire, capture;
  logic [W-1:0] tgt_q;

  assign fire    = valid_i & advance_i;
  assign taken_o = valid_i & is_br_i & cond_i & ~pend_q;
  assign capture = fire & is_br_i & ~pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      ptaken_q <= 1'b0;
      tgt_q    <= '0;
    end else if (fire) begin
      pend_q <= capture;  // slot consumes any pending decision
      if (capture) begin
        ptaken_q <= cond_i;
        tgt_q    <= target_i;
      end
    end
  end

  assign redirect_o = valid_i & pend_q & ptaken_q;
  assign nullify_o  = valid_i & pend_q & ~ptaken_q;
  assign hazard_o   = valid_i & pend_q & is_ctrl_i;
  assign target_o   = tgt_q;

  assert_taken_redirect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && taken_o) |=> (!valid_i || redirect_o));
  assert_untaken_nullify_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture && !cond_i) |=> (!valid_i || nullify_o));
  assert_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(redirect_o && nullify_o));
  assert_stall_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !advance_i && (redirect_o || nullify_o)) |=>
      ($stable(target_o) && (!valid_i || redirect_o || nullify_o)));
  assert_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (target_o[1:0] == 2'b00));
  assert_hazard_slot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hazard_o |-> (redirect_o || nullify_o) && !taken_o);
endmodule

// File: rtl/brl_resolve.sv
module brl_resolve
  import brl_pkg::*;
#(
  parameter int unsigned W     = XLEN,
  parameter int unsigned OFF_B = OFF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         advance_i,
  input  logic [W-1:0] instr_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] rs_val_i,
  input  logic [W-1:0] rt_val_i,
  output logic         taken_o,
  output logic [W-1:0] target_o,
  output logic         redirect_o,
  output logic         nullify_o,
  output logic         slot_hazard_o
);
  logic         is_br, is_ctrl, ne;
  logic [W-1:0] dec_tgt;

  brl_decode #(.W(W), .OFF_B(OFF_B)) u_dec (
    .instr_i  (instr_i),
    .pc_i     (pc_i),
    .is_br_o  (is_br),
    .is_ctrl_o(is_ctrl),
    .target_o (dec_tgt)
  );

  brl_compare #(.W(W)) u_cmp (
    .a_i (rs_val_i),
    .b_i (rt_val_i),
    .ne_o(ne)
  );

  brl_slot #(.W(W)) u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .advance_i (advance_i),
    .is_br_i   (is_br),
    .is_ctrl_i (is_ctrl),
    .cond_i    (ne),
    .target_i  (dec_tgt),
    .taken_o   (taken_o),
    .redirect_o(redirect_o),
    .nullify_o (nullify_o),
    .hazard_o  (slot_hazard_o),
    .target_o  (target_o)
  );

  assert_nonbranch_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_br) |-> !taken_o);
  assert_cond_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (rs_val_i != rt_val_i));
endmodule

// File: tb/brl_resolve_bench.sv
module brl_resolve_bench;
  localparam int CLK_P = 10;
  localparam logic [5:0] BR = 6'b010101;

  typedef struct {
    logic        taken, redirect, nullify, hazard, chk_tgt;
    logic [31:0] tgt;
    string       req;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, advance_i = 1'b0;
  logic [31:0] instr_i = '0, pc_i = '0, rs_val_i = '0, rt_val_i = '0;
  logic        taken_o, redirect_o, nullify_o, slot_hazard_o;
  logic [31:0] target_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  exp_t q[$];

  logic        m_pend = 1'b0, m_taken = 1'b0;
  logic [31:0] m_tgt = '0;

  always #(CLK_P/2) clk_i = ~clk_i;

  brl_resolve u_brl_resolve (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .advance_i(advance_i),
    .instr_i(instr_i), .pc_i(pc_i), .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
    .taken_o(taken_o), .target_o(target_o), .redirect_o(redirect_o),
    .nullify_o(nullify_o), .slot_hazard_o(slot_hazard_o)
  );

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [15:0] off);
    return {op, 5'd4, 5'd5, off};
  endfunction

  function automatic logic m_ctrl(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    logic [5:0] fn = w[5:0];
    if (op >= 6'd1 && op <= 6'd7) return 1'b1;
    if (op[5:2] == 4'b0101) return 1'b1;
    if (op == 6'd0 && (fn == 6'b001000 || fn == 6'b001001)) return 1'b1;
    if (op == 6'b010000 && w[25] && (fn == 6'b011000 || fn == 6'b011111 || fn == 6'b100000))
      return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] m_target(input logic [31:0] pc, input logic [31:0] w);
    return ({pc[31:2], 2'b00} + 32'd4) + {{14{w[15]}}, w[15:0], 2'b00};
  endfunction

  task automatic step(input logic [31:0] ins, input logic [31:0] pc,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic v, input logic adv, input string req);
    exp_t e;
    logic br;
    @(negedge clk_i);
    instr_i = ins; pc_i = pc; rs_val_i = a; rt_val_i = b; valid_i = v; advance_i = adv;
    br = (ins[31:26] == BR);
    e.taken    = v && br && (a != b) && !m_pend;
    e.redirect = v && m_pend && m_taken;
    e.nullify  = v && m_pend && !m_taken;
    e.hazard   = v && m_pend && m_ctrl(ins);
    e.chk_tgt  = v && m_pend && m_taken;
    e.tgt      = m_tgt;
    e.req      = req;
    q.push_back(e);
    if (rst_ni && v && adv) begin
      if (br && !m_pend) begin
        m_taken = (a != b);
        m_tgt   = m_target(pc, ins);
        m_pend  = 1'b1;
      end else m_pend = 1'b0;
    end
  endtask

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    exp_t e;
    forever begin
      @(negedge clk_i);
      #(CLK_P/4);
      if (q.size() > 0) begin
        e = q.pop_front();
        cmp(e.req, "taken", {31'd0, taken_o}, {31'd0, e.taken});
        cmp(e.req, "redirect", {31'd0, redirect_o}, {31'd0, e.redirect});
        cmp(e.req, "nullify", {31'd0, nullify_o}, {31'd0, e.nullify});
        cmp(e.req, "hazard", {31'd0, slot_hazard_o}, {31'd0, e.hazard});
        if (e.chk_tgt) cmp(e.req, "target", target_o, e.tgt);
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  localparam logic [31:0] ADD  = {6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'b100000};
  localparam logic [31:0] JMP  = {6'b000010, 26'h0};
  localparam logic [31:0] JREG = {6'd0, 5'd31, 15'd0, 6'b001000};
  localparam logic [31:0] ERET = {6'b010000, 1'b1, 19'd0, 6'b011000};

  initial begin
    // R8: reset state
    step(ADD, 32'h100, 1, 2, 1, 1, "R8");
    @(negedge clk_i); rst_ni = 1'b1;
    step(ADD, 32'h104, 1, 2, 1, 1, "R8");
    // R2 R3 R5: taken, positive offset
    step(mk(BR, 16'h0003), 32'h1000, 7, 9, 1, 1, "R2");
    step(ADD, 32'h1004, 0, 0, 1, 1, "R5_R3");
    // R6: not taken
    step(mk(BR, 16'h0003), 32'h1010, 5, 5, 1, 1, "R2");
    step(ADD, 32'h1014, 0, 0, 1, 1, "R6");
    // R3: offset -1 word, most negative, wrap
    step(mk(BR, 16'hFFFF), 32'h2000, 1, 0, 1, 1, "R3");
    step(ADD, 32'h2004, 0, 0, 1, 1, "R3");
    step(mk(BR, 16'h8000), 32'h0004_0000, 1, 0, 1, 1, "R3");
    step(ADD, 32'h0004_0004, 0, 0, 1, 1, "R3");
    step(mk(BR, 16'h0004), 32'hFFFF_FFF8, 3, 0, 1, 1, "R3");
    step(ADD, 32'hFFFF_FFFC, 0, 0, 1, 1, "R3");
    // R4: misaligned pc bits ignored
    step(mk(BR, 16'h0002), 32'h3003, 3, 0, 1, 1, "R4");
    step(ADD, 32'h3007, 0, 0, 1, 1, "R4");
    // R7: bubble and stall between branch and slot
    step(mk(BR, 16'h0010), 32'h4000, 8, 9, 1, 1, "R7");
    step(ADD, 32'h0, 0, 0, 0, 1, "R7");
    step(ADD, 32'h4004, 0, 0, 1, 0, "R7");
    step(ADD, 32'h4004, 0, 0, 1, 0, "R7");
    step(ADD, 32'h4004, 0, 0, 1, 1, "R7");
    step(ADD, 32'h4008, 0, 0, 1, 1, "R7");
    // R7: branch without advance is not captured
    step(mk(BR, 16'h0010), 32'h5000, 8, 9, 1, 0, "R7");
    step(ADD, 32'h5000, 0, 0, 1, 1, "R7");
    // R1: other opcode
    step(mk(6'b000101, 16'h0010), 32'h5100, 8, 9, 1, 1, "R1");
    step(ADD, 32'h5104, 0, 0, 1, 1, "R1");
    // R9: hazards in slot
    step(mk(BR, 16'h0001), 32'h6000, 1, 2, 1, 1, "R9");
    step(JMP, 32'h6004, 0, 0, 1, 1, "R9");
    step(mk(BR, 16'h0001), 32'h6100, 1, 1, 1, 1, "R9");
    step(JREG, 32'h6104, 0, 0, 1, 1, "R9");
    step(mk(BR, 16'h0001), 32'h6200, 1, 2, 1, 1, "R9");
    step(ERET, 32'h6204, 0, 0, 1, 1, "R9");
    step(mk(BR, 16'h0001), 32'h6300, 1, 2, 1, 1, "R9");
    step(mk(BR, 16'h0005), 32'h6304, 1, 2, 1, 1, "R9");
    step(ADD, 32'h6308, 0, 0, 1, 1, "R9");
    step(mk(BR, 16'h0001), 32'h6400, 1, 2, 1, 1, "R9");
    step(ADD, 32'h6404, 0, 0, 1, 1, "R9");
    // R8: reset discards pending
    step(mk(BR, 16'h0001), 32'h7000, 1, 2, 1, 1, "R8");
    @(negedge clk_i); rst_ni = 1'b0; m_pend = 1'b0;
    step(ADD, 32'h7004, 0, 0, 1, 1, "R8");
    @(negedge clk_i); rst_ni = 1'b1;
    step(ADD, 32'h7004, 0, 0, 1, 1, "R8");
    @(negedge clk_i);
    #(CLK_P);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule